// File: doc/BRIEF.md
# Video Output Channel Formatter

This block sits between the pixel pipeline and the parallel display pins. Each clock it accepts one pixel of three 12-bit components, qualified by a valid strobe and a data-enable that marks the active part of a line. The pixel passes through three registered stages. The first stage optionally exchanges the red and blue inputs and clamps each component to a programmable floor and ceiling, using one pair of limits for luma and another for chroma. The second stage reorders the three channels onto the output lanes, or packs a 4:2:2 luma/chroma pair onto two lanes. The third stage reduces or widens each lane to the selected output depth.

A two-bit format preset selects plain RGB, YCbCr 4:4:4 or YCbCr 4:2:2. In each preset the swap, channel order and packing are fixed. A fourth preset, custom, takes all three from their own configuration inputs. The configuration is assumed to be static while pixels are in flight, and the pipeline must be drained before any change. Colour-space matrices and sync timing are outside this block.

Top module: `vid_out_fmt`

## Requirements
- R1: `out_vld` and `out_de` equal `in_vld` and `in_de` from three clock edges earlier. A synchronous active-low reset drives `out_vld`, `out_de` and all three output lanes to zero.
- R2: Component 1 (luma/green) is clamped to [`cfg_y_lo`, `cfg_y_hi`], and components 0 and 2 are clamped to [`cfg_c_lo`, `cfg_c_hi`]. A value below the floor becomes the floor, and a value above the ceiling becomes the ceiling. The floor comparison is made first. Typical limits are 0x010 and 0xFE0.
- R3: When the red/blue swap is in effect, input component 0 and input component 2 are exchanged before clamping. The swap therefore also exchanges which chroma limits apply to the values.
- R4: Channel order codes (lane0, lane1, lane2), where R, G and B are components 0, 1 and 2 after the first stage: 0 = R,G,B; 1 = G,B,R; 2 = B,R,G; 3 = R,B,G; 4 = G,R,B; 5 = B,G,R. Codes 6 and 7 behave as code 0.
- R5: `cfg_fmt` presets. 0 (RGB): no swap, order R,G,B, no packing. 1 (YCbCr 4:4:4): no swap, order B,G,R, no packing. 2 (YCbCr 4:2:2): swap on, `cfg_order` ignored, packing per `cfg_map`, where a `cfg_map` outside 1..4 acts as 4. 3 (custom): swap, order and map are taken from `cfg_rb_swap`, `cfg_order` and `cfg_map`.
- R6: Map codes. 1: C on lane0 and Y on lane1 for even pixels, the reverse for odd pixels. 2: Y on lane0 and C on lane1 for even pixels, the reverse for odd pixels. 3: C on lane0, Y on lane1. 4: Y on lane0, C on lane1. Any other code gives three-lane channel ordering. When packing, Y is component 1 and lane2 is zero.
- R7: When packing, the chroma component is Cb (component 2) on even pixels and Cr (component 0) on odd pixels. The pixel index counts valid pixels with `in_de` high. It returns to 0 whenever `in_de` is low, and a pixel presented with `in_de` low uses index 0.
- R8: Depth codes place a value v[11:0] in a 16-bit lane as follows. 0: v[11:4] in bits 7:0. 1: v[11:2] in bits 9:0. 2: v in bits 11:0. 3: v in bits 15:4 with bits 3:0 zero. All unused upper lane bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Format preset |
| cfg_rb_swap | input | 1 | Red/blue swap, used in custom preset |
| cfg_order | input | 3 | Channel order code, used in custom preset |
| cfg_map | input | 3 | Luma/chroma lane map code |
| cfg_depth | input | 2 | Output depth code |
| cfg_y_lo | input | 12 | Luma floor |
| cfg_y_hi | input | 12 | Luma ceiling |
| cfg_c_lo | input | 12 | Chroma floor |
| cfg_c_hi | input | 12 | Chroma ceiling |
| in_vld | input | 1 | Input pixel valid |
| in_de | input | 1 | Input active-region enable |
| in_c0 | input | 12 | Component 0 (R / Cr) |
| in_c1 | input | 12 | Component 1 (G / Y) |
| in_c2 | input | 12 | Component 2 (B / Cb) |
| out_vld | output | 1 | Output pixel valid |
| out_de | output | 1 | Output active-region enable |
| out_l0 | output | 16 | Output lane 0 |
| out_l1 | output | 16 | Output lane 1 |
| out_l2 | output | 16 | Output lane 2 |

## Verification
The assertions check properties that hold on every cycle. These are the three-edge delay of valid and enable, the cleared outputs under reset, the luma lane staying inside its limits in the RGB preset, the zero lane2 while packing, and the zero padding required by the 8-bit and 16-bit depths. Exact lane contents need the bench's scenarios. These contents include which permutation was applied, whether red and blue were exchanged, and the Cb/Cr alternation and its restart after an enable gap. The bench sweeps every preset, order, map, depth and swap combination over lines that contain gaps. It also sweeps all 4096 input codes through the clamp.

// File: rtl/vof_pkg.sv
// Shared codes for the video output channel formatter.
// Assumes three components per pixel; code values are fixed by the requirements.
package vof_pkg;
    localparam int NCH = 3;

    typedef enum logic [1:0] {FMT_RGB, FMT_YUV444, FMT_YUV422, FMT_CUSTOM} fmt_e;
    typedef enum logic [1:0] {DEP_8, DEP_10, DEP_12, DEP_16} depth_e;

    localparam logic [2:0] ORD_RGB = 3'd0;
    localparam logic [2:0] ORD_GBR = 3'd1;
    localparam logic [2:0] ORD_BRG = 3'd2;
    localparam logic [2:0] ORD_RBG = 3'd3;
    localparam logic [2:0] ORD_GRB = 3'd4;
    localparam logic [2:0] ORD_BGR = 3'd5;

    localparam logic [2:0] MAP_PASS = 3'd0;
    localparam logic [2:0] MAP_CYCY = 3'd1;
    localparam logic [2:0] MAP_YCYC = 3'd2;
    localparam logic [2:0] MAP_CY   = 3'd3;
    localparam logic [2:0] MAP_YC   = 3'd4;
endpackage

// File: rtl/vof_front.sv
// Stage 1: optional exchange of components 0 and 2, then per-component clamp.
// Assumes lo/hi limits are static while pixels flow; component 1 uses the luma
// limits, the others the chroma limits. One register of latency.
module vof_front import vof_pkg::*; #(
    parameter int CW = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    swap,
    input  logic [CW-1:0]           y_lo,
    input  logic [CW-1:0]           y_hi,
    input  logic [CW-1:0]           c_lo,
    input  logic [CW-1:0]           c_hi,
    input  logic                    vld_i,
    input  logic                    de_i,
    input  logic [NCH-1:0][CW-1:0]  d_i,
    output logic                    vld_o,
    output logic                    de_o,
    output logic [NCH-1:0][CW-1:0]  d_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        localparam int SRC = (i == 1) ? 1 : (NCH - 1 - i);
        logic [CW-1:0] raw, lo, hi, cl, q;

        assign raw = swap ? d_i[SRC] : d_i[i];
        assign lo  = (i == 1) ? y_lo : c_lo;
        assign hi  = (i == 1) ? y_hi : c_hi;

        // Saturate against the floor first, then the ceiling.
        always_comb begin
            if (raw < lo)      cl = lo;
            else if (raw > hi) cl = hi;
            else               cl = raw;
        end

        // Register the clamped component.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= cl;
        end

        assign d_o[i] = q;
    end

    // Carry the qualifiers alongside the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            de_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            de_o  <= de_i;
        end
    end
endmodule

// File: rtl/vof_arrange.sv
// Stage 2: channel permutation or 4:2:2 luma/chroma lane packing.
// Assumes component 1 is luma, 2 is Cb and 0 is Cr when packing. Tracks pixel
// parity within the active region to alternate chroma. One register of latency.
module vof_arrange import vof_pkg::*; #(
    parameter int CW = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              order,
    input  logic [2:0]              map,
    input  logic                    vld_i,
    input  logic                    de_i,
    input  logic [NCH-1:0][CW-1:0]  d_i,
    output logic                    vld_o,
    output logic                    de_o,
    output logic [NCH-1:0][CW-1:0]  d_o
);
    logic                    par, pb;
    logic [CW-1:0]           cc, yy;
    logic [NCH-1:0][CW-1:0]  nxt;

    // Select chroma by parity and build the next lane set.
    always_comb begin
        pb  = de_i & par;
        cc  = pb ? d_i[0] : d_i[2];
        yy  = d_i[1];
        nxt = '0;
        case (map)
            MAP_CYCY: begin nxt[0] = pb ? yy : cc; nxt[1] = pb ? cc : yy; end
            MAP_YCYC: begin nxt[0] = pb ? cc : yy; nxt[1] = pb ? yy : cc; end
            MAP_CY:   begin nxt[0] = cc; nxt[1] = yy; end
            MAP_YC:   begin nxt[0] = yy; nxt[1] = cc; end
            default: begin
                case (order)
                    ORD_GBR: nxt = {d_i[0], d_i[2], d_i[1]};
                    ORD_BRG: nxt = {d_i[1], d_i[0], d_i[2]};
                    ORD_RBG: nxt = {d_i[1], d_i[2], d_i[0]};
                    ORD_GRB: nxt = {d_i[2], d_i[0], d_i[1]};
                    ORD_BGR: nxt = {d_i[0], d_i[1], d_i[2]};
                    default: nxt = d_i;
                endcase
            end
        endcase
    end

    // Parity restarts whenever the active-region enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)     par <= 1'b0;
        else if (!de_i) par <= 1'b0;
        else if (vld_i) par <= ~par;
    end

    // Register the arranged lanes and qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_o   <= '0;
            vld_o <= 1'b0;
            de_o  <= 1'b0;
        end else begin
            d_o   <= nxt;
            vld_o <= vld_i;
            de_o  <= de_i;
        end
    end
endmodule

// File: rtl/vof_depth.sv
// Stage 3: fit each lane to the selected output depth.
// Assumes CW >= 12 and LW >= CW; narrow depths keep the MSBs, the widest
// left-justifies with zero fill. One register of latency.
module vof_depth import vof_pkg::*; #(
    parameter int CW = 12,
    parameter int LW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              depth,
    input  logic                    vld_i,
    input  logic                    de_i,
    input  logic [NCH-1:0][CW-1:0]  d_i,
    output logic                    vld_o,
    output logic                    de_o,
    output logic [NCH-1:0][LW-1:0]  d_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        logic [LW-1:0] f, q;

        // Truncate or left-justify according to the depth code.
        always_comb begin
            f = '0;
            case (depth_e'(depth))
                DEP_8:   f[7:0]       = d_i[i][CW-1 -: 8];
                DEP_10:  f[9:0]       = d_i[i][CW-1 -: 10];
                DEP_12:  f[11:0]      = d_i[i][CW-1 -: 12];
                default: f[LW-1 -: CW] = d_i[i];
            endcase
        end

        // Register the formatted lane.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= f;
        end

        assign d_o[i] = q;
    end

    // Carry the qualifiers to the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            de_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            de_o  <= de_i;
        end
    end
endmodule

// File: rtl/vid_out_fmt.sv
// Video output channel formatter top: preset decode plus three pipeline stages
// (swap/clamp, arrange, depth). Fixed latency of three clock edges.
// Assumes configuration inputs are stable while pixels are in the pipeline.
module vid_out_fmt import vof_pkg::*; #(
    parameter int CW = 12,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_fmt,
    input  logic          cfg_rb_swap,
    input  logic [2:0]    cfg_order,
    input  logic [2:0]    cfg_map,
    input  logic [1:0]    cfg_depth,
    input  logic [CW-1:0] cfg_y_lo,
    input  logic [CW-1:0] cfg_y_hi,
    input  logic [CW-1:0] cfg_c_lo,
    input  logic [CW-1:0] cfg_c_hi,
    input  logic          in_vld,
    input  logic          in_de,
    input  logic [CW-1:0] in_c0,
    input  logic [CW-1:0] in_c1,
    input  logic [CW-1:0] in_c2,
    output logic          out_vld,
    output logic          out_de,
    output logic [LW-1:0] out_l0,
    output logic [LW-1:0] out_l1,
    output logic [LW-1:0] out_l2
);
    logic                    eff_swap;
    logic [2:0]              eff_order, eff_map;
    logic                    s1_vld, s1_de, s2_vld, s2_de;
    logic [NCH-1:0][CW-1:0]  s1_d, s2_d;
    logic [NCH-1:0][LW-1:0]  s3_d;

    // Resolve the format preset into swap, order and lane map.
    always_comb begin
        case (fmt_e'(cfg_fmt))
            FMT_RGB:    begin eff_swap = 1'b0; eff_order = ORD_RGB; eff_map = MAP_PASS; end
            FMT_YUV444: begin eff_swap = 1'b0; eff_order = ORD_BGR; eff_map = MAP_PASS; end
            FMT_YUV422: begin
                eff_swap  = 1'b1;
                eff_order = ORD_RGB;
                eff_map   = (cfg_map >= MAP_CYCY && cfg_map <= MAP_YC) ? cfg_map : MAP_YC;
            end
            default:    begin eff_swap = cfg_rb_swap; eff_order = cfg_order; eff_map = cfg_map; end
        endcase
    end

    vof_front #(.CW(CW)) u_front (
        .clk(clk), .rst_n(rst_n), .swap(eff_swap),
        .y_lo(cfg_y_lo), .y_hi(cfg_y_hi), .c_lo(cfg_c_lo), .c_hi(cfg_c_hi),
        .vld_i(in_vld), .de_i(in_de), .d_i({in_c2, in_c1, in_c0}),
        .vld_o(s1_vld), .de_o(s1_de), .d_o(s1_d)
    );

    vof_arrange #(.CW(CW)) u_arrange (
        .clk(clk), .rst_n(rst_n), .order(eff_order), .map(eff_map),
        .vld_i(s1_vld), .de_i(s1_de), .d_i(s1_d),
        .vld_o(s2_vld), .de_o(s2_de), .d_o(s2_d)
    );

    vof_depth #(.CW(CW), .LW(LW)) u_depth (
        .clk(clk), .rst_n(rst_n), .depth(cfg_depth),
        .vld_i(s2_vld), .de_i(s2_de), .d_i(s2_d),
        .vld_o(out_vld), .de_o(out_de), .d_o(s3_d)
    );

    assign out_l0 = s3_d[0];
    assign out_l1 = s3_d[1];
    assign out_l2 = s3_d[2];
endmodule

// File: rtl/vof_checker.sv
// Cycle-level checks on the formatter's pins, bound into every instance.
// Assumes configuration is only changed while the pipeline is empty.
module vof_checker #(
    parameter int CW = 12,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_fmt,
    input logic [1:0]    cfg_depth,
    input logic [CW-1:0] cfg_y_lo,
    input logic [CW-1:0] cfg_y_hi,
    input logic          in_vld,
    input logic          in_de,
    input logic          out_vld,
    input logic          out_de,
    input logic [LW-1:0] out_l0,
    input logic [LW-1:0] out_l1,
    input logic [LW-1:0] out_l2
);
    logic [1:0] warm;

    // Count edges since reset, saturating once the pipeline is full.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R1
    AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_de == $past(in_de, 3))); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !out_de && out_l0 == '0 && out_l1 == '0 && out_l2 == '0)); // R1
    AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && cfg_fmt == 2'd0 && cfg_depth == 2'd2 && cfg_y_lo <= cfg_y_hi)
        |-> (out_l1 >= LW'(cfg_y_lo) && out_l1 <= LW'(cfg_y_hi))); // R2
    AST_PACK_LANE2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && cfg_fmt == 2'd2) |-> (out_l2 == '0)); // R6
    AST_WIDE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && cfg_depth == 2'd3)
        |-> (out_l0[LW-CW-1:0] == '0 && out_l1[LW-CW-1:0] == '0 && out_l2[LW-CW-1:0] == '0)); // R8
    AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && cfg_depth == 2'd0)
        |-> (out_l0[LW-1:8] == '0 && out_l1[LW-1:8] == '0 && out_l2[LW-1:8] == '0)); // R8
endmodule

bind vid_out_fmt vof_checker #(.CW(CW), .LW(LW)) u_vof_chk (.*);

// File: tb/vid_out_fmt_test.sv
module vid_out_fmt_test;
    localparam int CW = 12;
    localparam int LW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [1:0]    cfg_fmt, cfg_depth;
    logic          cfg_rb_swap;
    logic [2:0]    cfg_order, cfg_map;
    logic [CW-1:0] cfg_y_lo, cfg_y_hi, cfg_c_lo, cfg_c_hi;
    logic          in_vld, in_de;
    logic [CW-1:0] in_c0, in_c1, in_c2;
    logic          out_vld, out_de;
    logic [LW-1:0] out_l0, out_l1, out_l2;

    vid_out_fmt #(.CW(CW), .LW(LW)) uut (.*);

    int nchk = 0;
    int nfail = 0;
    logic [2:0] hv, hd;
    logic pm;
    string cur_tag;
    logic [3*LW-1:0] expq[$];
    string tagq[$];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] clampf(logic [CW-1:0] x, logic [CW-1:0] lo, logic [CW-1:0] hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic logic [LW-1:0] depf(logic [CW-1:0] v);
        case (cfg_depth)
            2'd0: return LW'(v / 16);
            2'd1: return LW'(v / 4);
            2'd2: return LW'(v);
            default: return LW'(v) * 16;
        endcase
    endfunction

    // Expected lanes from the requirement text (R2..R8).
    function automatic logic [3*LW-1:0] model(logic [CW-1:0] a, logic [CW-1:0] b, logic [CW-1:0] c, logic pb);
        logic sw;
        logic [2:0] od, mp;
        logic [CW-1:0] x[3];
        logic [CW-1:0] o[3];
        logic [CW-1:0] cc;
        logic cfirst;
        int s0, s1, s2;
        case (cfg_fmt)
            2'd0: begin sw = 0; od = 0; mp = 0; end
            2'd1: begin sw = 0; od = 5; mp = 0; end
            2'd2: begin sw = 1; od = 0; mp = (cfg_map >= 1 && cfg_map <= 4) ? cfg_map : 3'd4; end
            default: begin sw = cfg_rb_swap; od = cfg_order; mp = cfg_map; end
        endcase
        x[0] = clampf(sw ? c : a, cfg_c_lo, cfg_c_hi);
        x[1] = clampf(b, cfg_y_lo, cfg_y_hi);
        x[2] = clampf(sw ? a : c, cfg_c_lo, cfg_c_hi);
        if (mp >= 1 && mp <= 4) begin
            cc = pb ? x[0] : x[2];
            cfirst = (mp == 3) || (mp == 1 && !pb) || (mp == 2 && pb);
            o[0] = cfirst ? cc : x[1];
            o[1] = cfirst ? x[1] : cc;
            o[2] = '0;
        end else begin
            case (od)
                3'd1: begin s0 = 1; s1 = 2; s2 = 0; end
                3'd2: begin s0 = 2; s1 = 0; s2 = 1; end
                3'd3: begin s0 = 0; s1 = 2; s2 = 1; end
                3'd4: begin s0 = 1; s1 = 0; s2 = 2; end
                3'd5: begin s0 = 2; s1 = 1; s2 = 0; end
                default: begin s0 = 0; s1 = 1; s2 = 2; end
            endcase
            o[0] = x[s0]; o[1] = x[s1]; o[2] = x[s2];
        end
        return {depf(o[2]), depf(o[1]), depf(o[0])};
    endfunction

    // Check the outputs for the pixel driven three steps ago, then drive a new one.
    task automatic step(logic v, logic d, logic [CW-1:0] a, logic [CW-1:0] b, logic [CW-1:0] c);
        logic pb;
        @(negedge clk);
        chk("R1 valid delay", 64'(out_vld), 64'(hv[2]));
        chk("R1 de delay", 64'(out_de), 64'(hd[2]));
        if (out_vld) begin
            if (expq.size() == 0) chk("R1 unexpected pixel", 64'd1, 64'd0);
            else chk(tagq.pop_front(), 64'({out_l2, out_l1, out_l0}), 64'(expq.pop_front()));
        end
        hv = {hv[1:0], v};
        hd = {hd[1:0], d};
        in_vld = v; in_de = d; in_c0 = a; in_c1 = b; in_c2 = c;
        if (!d) begin pb = 1'b0; pm = 1'b0; end
        else begin pb = pm; if (v) pm = ~pm; end
        if (v) begin
            expq.push_back(model(a, b, c, pb));
            tagq.push_back(cur_tag);
        end
    endtask

    function automatic logic [CW-1:0] pv(int n, int k, int l);
        return CW'((n * 37 + k * 611 + l * 1291 + 5) & 12'hFFF);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0;
        cfg_fmt = 0; cfg_rb_swap = 0; cfg_order = 0; cfg_map = 0; cfg_depth = 2;
        cfg_y_lo = 12'h010; cfg_y_hi = 12'hFE0; cfg_c_lo = 12'h010; cfg_c_hi = 12'hFE0;
        in_vld = 1'b1; in_de = 1'b1; in_c0 = 12'hFFF; in_c1 = 12'hABC; in_c2 = 12'h123;
        hv = '0; hd = '0; pm = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset clear", 64'({out_vld, out_de, out_l2, out_l1, out_l0}), 64'd0);
        in_vld = 1'b0; in_de = 1'b0;
        rst_n = 1'b1;

        // Sweep every preset, order, map, depth and swap setting (R3..R8).
        n = 0;
        for (int fm = 0; fm < 4; fm++)
            for (int od = 0; od < 8; od++)
                for (int mp = 0; mp < 8; mp++)
                    for (int dp = 0; dp < 4; dp++)
                        for (int sw = 0; sw < 2; sw++) begin
                            cfg_fmt = 2'(fm); cfg_order = 3'(od); cfg_map = 3'(mp);
                            cfg_depth = 2'(dp); cfg_rb_swap = sw[0];
                            if (fm == 2 || (fm == 3 && mp >= 1 && mp <= 4)) cur_tag = "R6 R7 R8 pack";
                            else if (fm == 1) cur_tag = "R5 R8 yuv444";
                            else if (fm == 0) cur_tag = "R5 R2 R8 rgb";
                            else if (sw == 1) cur_tag = "R3 R4 R8 swap";
                            else cur_tag = "R4 R8 order";
                            step(1, 1, 12'h000, 12'h000, 12'h000);
                            step(1, 1, 12'hFFF, 12'hFFF, 12'hFFF);
                            step(0, 1, pv(n, 9, 0), pv(n, 9, 1), pv(n, 9, 2));
                            for (int k = 0; k < 3; k++) step(1, 1, pv(n, k, 0), pv(n, k, 1), pv(n, k, 2));
                            step(1, 0, pv(n, 5, 0), pv(n, 5, 1), pv(n, 5, 2));
                            for (int k = 6; k < 8; k++) step(1, 1, pv(n, k, 0), pv(n, k, 1), pv(n, k, 2));
                            repeat (4) step(0, 0, 0, 0, 0);
                            n++;
                        end

        // Full-code clamp sweep with narrowed limits (R2).
        cfg_fmt = 2'd3; cfg_order = 0; cfg_map = 0; cfg_depth = 2'd2; cfg_rb_swap = 0;
        cfg_y_lo = 12'h100; cfg_y_hi = 12'hE00; cfg_c_lo = 12'h080; cfg_c_hi = 12'hF00;
        cur_tag = "R2 clamp";
        for (int i = 0; i < 4096; i++)
            step(1, 1, CW'(i), CW'(4095 - i), CW'((i * 7) & 12'hFFF));
        repeat (4) step(0, 0, 0, 0, 0);
        chk("R1 queue drained", 64'(expq.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule